// File: doc/BRIEF.md
# I2C Register Target Engine

This block is a target on a two-wire serial bus, clocked by a fast system clock that oversamples the bus lines. It recognises START and STOP conditions, compares the first byte of a transfer against a fixed 4-bit device-type value and a 3-bit strapped bus address, and then turns the transfer into accesses on a simple byte-wide register port. The register port has an address, write data, a write strobe, combinational read data and a read strobe.

A write transfer carries a pointer byte followed by one or more data bytes. Each data byte is written at the pointer, and the pointer then advances inside its 16-byte page. A STOP that closes a transfer with at least one accepted data byte raises a one-cycle commit pulse, which tells the storage behind the port to start its nonvolatile write. A read transfer first loads the pointer with a write that has no STOP. A repeated START with the read bit set follows, and bytes are then returned from the pointer onward. The pointer advances on each byte the controller acknowledges, and the read ends when the controller sends a NACK followed by a STOP.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the target does not drive the bus (`sda_oe` low) and raises no register strobe and no commit.
- R2: The target sees a START when SDA falls while SCL is high and a STOP when SDA rises while SCL is high. When the address byte matches, it pulls SDA low during the acknowledge clock. Address byte layout, MSB first: bits 7:4 are the device type (default 4'b1010), bits 3:1 are the bus address, and bit 0 is read (1) or write (0).
- R3: The target does not acknowledge an address byte whose device type or bus address differs. It then makes no register access and no commit until the next START.
- R4: The target acknowledges the pointer byte and each write data byte. Each data byte appears on `reg_wdata` with a one-cycle `reg_we` at the current pointer. Bits are sampled MSB first on rising SCL.
- R5: After each written byte the pointer advances in its low 4 bits only, so successive writes wrap within the 16-byte page (0x3E, 0x3F, 0x30, ...).
- R6: `commit` pulses for one cycle after a STOP only when the transfer since the last START wrote at least one data byte. A pointer-only write and a read give no commit.
- R7: After a pointer write and a repeated START with the read bit set, the first byte returned is the data at the pointer. It is driven MSB first, with each bit changing after falling SCL (`sda_oe` high means SDA is driven low).
- R8: During a read the pointer advances by one over its full width on each acknowledged byte, crossing page boundaries. It does not advance on the NACKed byte, so a later read without a pointer write resumes at that byte.
- R9: `reg_we` and `reg_re` are single-cycle pulses, never both high, with one `reg_re` per byte taken for transmission.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line sample |
| sda_i | input | 1 | Serial data line sample |
| sda_oe | output | 1 | Pull SDA low when high (open-drain enable) |
| bus_addr_i | input | 3 | Strapped bus address |
| reg_addr | output | 8 | Register port address (current pointer) |
| reg_wdata | output | 8 | Register port write data |
| reg_we | output | 1 | Register write strobe |
| reg_rdata | input | 8 | Register read data for `reg_addr`, combinational |
| reg_re | output | 1 | Pulse marking that a read byte was taken |
| commit | output | 1 | Pulse asking for the nonvolatile write |

## Verification
The properties assume that every SCL high and low phase lasts much longer than the synchroniser latency. They also assume that the controller moves SDA only while SCL is low, except for START and STOP. With these, the edges the target sees arrive in the same order as on the wires. The stimulus holds each quarter of an SCL period for ten system clocks and releases SDA before every acknowledge or read bit. It issues START and repeated START only while the target has SDA released.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_DEV, ST_DEV_ACK, ST_PTR, ST_PTR_ACK,
      ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
   } i2ct_state_e;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic q,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("i2ct_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              q_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         q_d   <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         q_d   <= chain[STAGES-1];
      end
   end

   assign q    = chain[STAGES-1];
   assign rise = q & ~q_d;
   assign fall = ~q & q_d;
endmodule

// File: rtl/i2ct_ptr.sv
module i2ct_ptr #(
   parameter int ADDR_W    = 8,
   parameter int PAGE_BITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc_page,
   input  logic              inc_full,
   output logic [ADDR_W-1:0] ptr
);
   logic [ADDR_W-1:0] nxt_page;

   generate
      if (PAGE_BITS >= ADDR_W) begin : g_flat
         assign nxt_page = ptr + 1'b1;
      end else begin : g_paged
         assign nxt_page = {ptr[ADDR_W-1:PAGE_BITS],
                            PAGE_BITS'(ptr[PAGE_BITS-1:0] + 1'b1)};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr <= '0;
      else if (load)     ptr <= load_val;
      else if (inc_page) ptr <= nxt_page;
      else if (inc_full) ptr <= ptr + 1'b1;
   end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
   parameter logic [3:0] DEV_TYPE    = 4'b1010,
   parameter int         SYNC_STAGES = 2,
   parameter int         ADDR_W      = 8,
   parameter int         DATA_W      = 8,
   parameter int         PAGE_BITS   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [2:0]        bus_addr_i,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              reg_re,
   output logic              commit
);
   import i2ct_pkg::*;

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);

   generate
      if (DATA_W != 8 || ADDR_W != 8) begin : g_chk_w
         $error("byte-wide bus framing requires 8-bit address and data");
      end
      if (PAGE_BITS < 1 || PAGE_BITS > ADDR_W) begin : g_chk_p
         $error("PAGE_BITS out of range");
      end
   endgenerate

   logic scl_q, scl_rise, scl_fall, scl_r_unused;
   logic sda_q, sda_rise, sda_fall;
   logic start_c, stop_c;

   i2ct_sync #(.STAGES(SYNC_STAGES)) u_scl (
      .clk(clk), .rst_n(rst_n), .din(scl_i),
      .q(scl_q), .rise(scl_rise), .fall(scl_fall));
   i2ct_sync #(.STAGES(SYNC_STAGES)) u_sda (
      .clk(clk), .rst_n(rst_n), .din(sda_i),
      .q(sda_q), .rise(sda_rise), .fall(sda_fall));

   assign scl_r_unused = scl_rise & 1'b0;
   assign start_c = sda_fall & scl_q;
   assign stop_c  = sda_rise & scl_q;

   i2ct_state_e       state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg, tx;
   logic              rw, pend, acked;
   logic              ld_q, incp_q, incf_q;
   logic [ADDR_W-1:0] ptr_val;

   i2ct_ptr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(ld_q), .load_val(ptr_val),
      .inc_page(incp_q), .inc_full(incf_q), .ptr(reg_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         shreg     <= '0;
         tx        <= '0;
         rw        <= 1'b0;
         pend      <= 1'b0;
         acked     <= 1'b0;
         sda_oe    <= 1'b0;
         reg_we    <= 1'b0;
         reg_re    <= 1'b0;
         reg_wdata <= '0;
         commit    <= 1'b0;
         ld_q      <= 1'b0;
         incp_q    <= 1'b0;
         incf_q    <= 1'b0;
         ptr_val   <= '0;
      end else begin
         reg_we <= 1'b0;
         reg_re <= 1'b0;
         commit <= 1'b0;
         ld_q   <= 1'b0;
         incp_q <= 1'b0;
         incf_q <= 1'b0;
         if (start_c) begin
            state  <= ST_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
            pend   <= 1'b0;
         end else if (stop_c) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            commit <= pend;
            pend   <= 1'b0;
         end else begin
            case (state)
               ST_DEV, ST_PTR, ST_WR: begin
                  if (scl_rise && cnt != BYTE_END) begin
                     shreg <= {shreg[DATA_W-2:0], sda_q};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == BYTE_END) begin
                     cnt <= '0;
                     if (state == ST_DEV) begin
                        if (shreg[7:4] == DEV_TYPE && shreg[3:1] == bus_addr_i) begin
                           rw     <= shreg[0];
                           sda_oe <= 1'b1;
                           state  <= ST_DEV_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_PTR) begin
                        ptr_val <= shreg;
                        ld_q    <= 1'b1;
                        sda_oe  <= 1'b1;
                        state   <= ST_PTR_ACK;
                     end else begin
                        reg_wdata <= shreg;
                        reg_we    <= 1'b1;
                        pend      <= 1'b1;
                        sda_oe    <= 1'b1;
                        state     <= ST_WR_ACK;
                     end
                  end
               end
               ST_DEV_ACK: if (scl_fall) begin
                  if (rw) begin
                     tx     <= reg_rdata;
                     reg_re <= 1'b1;
                     sda_oe <= ~reg_rdata[DATA_W-1];
                     state  <= ST_RD;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_PTR;
                  end
               end
               ST_PTR_ACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  state  <= ST_WR;
               end
               ST_WR_ACK: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  incp_q <= 1'b1;
                  state  <= ST_WR;
               end
               ST_RD: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == BYTE_END) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_RD_ACK;
                     end else begin
                        tx     <= {tx[DATA_W-2:0], 1'b0};
                        sda_oe <= ~tx[DATA_W-2];
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     acked  <= ~sda_q;
                     incf_q <= ~sda_q;
                  end else if (scl_fall) begin
                     if (acked) begin
                        tx     <= reg_rdata;
                        reg_re <= 1'b1;
                        sda_oe <= ~reg_rdata[DATA_W-1];
                        state  <= ST_RD;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_oe,
   input logic reg_we,
   input logic reg_re,
   input logic commit
);
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!sda_oe && !reg_we && !reg_re && !commit));
   p_commit_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);
   p_commit_scl_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> scl_i);
   p_we_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);
   p_re_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> !reg_re);
   p_we_re_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re));
   p_oe_rise_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);
   p_oe_fall_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> !scl_i);
endmodule

bind i2c_reg_target i2ct_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
   .reg_we(reg_we), .reg_re(reg_re), .commit(commit));

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe;
   logic       sda_line;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic       reg_we, reg_re, commit;
   logic [7:0] mem [256];
   logic [7:0] exp_mem [256];
   logic [15:0] exp_q [$];
   int n_chk = 0, n_fail = 0;
   int n_commit = 0, n_re = 0, n_we = 0, n_oe_bad = 0;
   logic done = 1'b0;
   logic prev_oe = 1'b0;

   always #4 clk = ~clk;

   assign sda_line  = sda_m & ~sda_oe;
   assign reg_rdata = mem[reg_addr];

   i2c_reg_target u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .bus_addr_i(3'b101), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
      .reg_re(reg_re), .commit(commit));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: scoreboard and event counters
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_we) begin
            n_we++;
            mem[reg_addr] <= reg_wdata;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3/R4 unexpected write", {reg_addr, reg_wdata}, 0);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               chk({reg_addr, reg_wdata} == e, "R4/R5 write", {reg_addr, reg_wdata}, e);
            end
         end
         if (reg_re) n_re++;
         if (commit) n_commit++;
         if (sda_oe != prev_oe && scl_m) n_oe_bad++;
         prev_oe <= sda_oe;
      end
   end

   task automatic wq();
      repeat (10) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
      end
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      ack = ~sda_line;
      wq(); scl_m = 1'b0; wq();
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(); scl_m = 1'b1; wq();
         b[i] = sda_line;
         wq(); scl_m = 1'b0; wq();
      end
      sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
      sda_m = 1'b1;
   endtask

   task automatic push_wr(input logic [7:0] a, input logic [7:0] d);
      exp_q.push_back({a, d});
      exp_mem[a] = d;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bit ack;
      logic [7:0] rb;
      int c0, w0, r0;
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'(i) ^ 8'h5A;
         exp_mem[i] = 8'(i) ^ 8'h5A;
      end
      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
      chk(reg_we == 1'b0 && reg_re == 1'b0, "R1 strobes", {reg_we, reg_re}, 0);
      rst_n = 1'b1;
      wq();
      chk(sda_oe == 1'b0 && commit == 1'b0, "R1 after release", {sda_oe, commit}, 0);

      // single byte write
      push_wr(8'h12, 8'hA5);
      i2c_start();
      send_byte(8'hAA, ack); chk(ack, "R2 address ack", ack, 1);
      send_byte(8'h12, ack); chk(ack, "R4 pointer ack", ack, 1);
      send_byte(8'hA5, ack); chk(ack, "R4 data ack", ack, 1);
      i2c_stop();
      chk(n_commit == 1, "R6 commit after write", n_commit, 1);

      // page write wrapping in the page
      push_wr(8'h3E, 8'h11); push_wr(8'h3F, 8'h22);
      push_wr(8'h30, 8'h33); push_wr(8'h31, 8'h44);
      i2c_start();
      send_byte(8'hAA, ack); chk(ack, "R2 address ack", ack, 1);
      send_byte(8'h3E, ack); chk(ack, "R4 pointer ack", ack, 1);
      send_byte(8'h11, ack); chk(ack, "R5 data ack", ack, 1);
      send_byte(8'h22, ack); chk(ack, "R5 data ack", ack, 1);
      send_byte(8'h33, ack); chk(ack, "R5 data ack", ack, 1);
      send_byte(8'h44, ack); chk(ack, "R5 data ack", ack, 1);
      i2c_stop();
      chk(n_commit == 2, "R6 commit after page", n_commit, 2);
      chk(exp_q.size() == 0, "R5 all page writes seen", exp_q.size(), 0);

      // mismatched bus address, then mismatched device type
      c0 = n_commit; w0 = n_we;
      i2c_start();
      send_byte(8'hA8, ack); chk(!ack, "R3 bus address nack", ack, 0);
      send_byte(8'h20, ack); chk(!ack, "R3 ignored byte", ack, 0);
      send_byte(8'h77, ack);
      i2c_stop();
      i2c_start();
      send_byte(8'h9A, ack); chk(!ack, "R3 device type nack", ack, 0);
      send_byte(8'h20, ack);
      i2c_stop();
      chk(n_we == w0, "R3 no write", n_we - w0, 0);
      chk(n_commit == c0, "R3 no commit", n_commit - c0, 0);

      // pointer write, repeated start, read across page boundary
      r0 = n_re;
      i2c_start();
      send_byte(8'hAA, ack); chk(ack, "R2 address ack", ack, 1);
      send_byte(8'h3F, ack); chk(ack, "R7 pointer ack", ack, 1);
      i2c_start();
      send_byte(8'hAB, ack); chk(ack, "R7 read address ack", ack, 1);
      recv_byte(1'b1, rb); chk(rb == exp_mem[8'h3F], "R7 first byte", rb, exp_mem[8'h3F]);
      recv_byte(1'b1, rb); chk(rb == exp_mem[8'h40], "R8 next byte", rb, exp_mem[8'h40]);
      recv_byte(1'b0, rb); chk(rb == exp_mem[8'h41], "R8 last byte", rb, exp_mem[8'h41]);
      i2c_stop();
      chk(n_commit == c0, "R6 no commit on read", n_commit - c0, 0);
      chk(n_re - r0 == 3, "R9 read strobes", n_re - r0, 3);

      // read resumes at the NACKed byte
      i2c_start();
      send_byte(8'hAB, ack); chk(ack, "R8 read address ack", ack, 1);
      recv_byte(1'b0, rb); chk(rb == exp_mem[8'h41], "R8 resume", rb, exp_mem[8'h41]);
      i2c_stop();

      chk(n_oe_bad == 0, "R10 sda_oe while scl high", n_oe_bad, 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule